// File: doc/BRIEF.md
# Saturating Iteration Counter

This block counts the shift-and-add steps of a serial multiplier. After a synchronous reset it holds zero. On each later rising clock edge it steps up by one until it reaches its terminal value of four. It does not wrap. It stays at four until reset is asserted again. A decoded flag marks the terminal value, and the sequencing controller uses that flag to know that the iterations are finished.

Each count bit is kept in its own toggle-type storage cell. A small next-state stage works out which bits must flip on the coming edge. Codes above the terminal value cannot be reached in normal use. If one of them is ever entered, the counter returns to zero on the next clock.

Top module: `itc_sat_counter`

## Requirements
- R1: While `rst_i` is high at a rising edge of `clk_i`, the following cycle shows `count_o` equal to 0 and `term_o` low.
- R2: With `rst_i` low and `count_o` below 4, each rising edge raises `count_o` by exactly one (0→1→2→3→4).
- R3: With `rst_i` low and `count_o` equal to 4, every later rising edge leaves `count_o` at 4.
- R4: Reset takes priority over counting and over holding. Asserting `rst_i` at any count, including the terminal value 4, returns `count_o` to 0, and counting then starts again from 0.
- R5: `term_o` is high exactly when `count_o` is 3'b100 (decimal 4), and low for every other count.
- R6: Once reset has been applied, `count_o` never shows a value above 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset to count 0 |
| count_o | output | 3 | Current iteration count, binary |
| term_o | output | 1 | High when the count sits at the terminal value 4 |

## Verification
The assertions take for granted that `rst_i` is applied at least once before any property is evaluated. They also take for granted that `rst_i` changes only away from the rising edge of `clk_i`. Until a first reset, the cell contents are undefined, so the properties stay disarmed. The stimulus therefore opens with reset high and drives `rst_i` only on falling edges. From there it runs long stretches past saturation and places reset pulses at intermediate counts and at the terminal count. It also holds reset for several cycles in a row.

// File: rtl/itc_pkg.sv
package itc_pkg;

    // Default geometry of the iteration counter
    localparam int unsigned ITC_WIDTH = 3;
    localparam int unsigned ITC_LAST  = 4;

    // Where the present count sits relative to the terminal value
    typedef enum logic [1:0] {
        POS_RUN   = 2'd0,  // below terminal: advance
        POS_LAST  = 2'd1,  // at terminal: hold
        POS_STRAY = 2'd2   // above terminal: recover to zero
    } pos_e;

    // Result of one next-state evaluation
    typedef struct packed {
        pos_e pos;
        logic at_last;
    } step_info_t;

    function automatic pos_e classify(input int unsigned cur, input int unsigned last);
        if (cur < last)       return POS_RUN;
        else if (cur == last) return POS_LAST;
        else                  return POS_STRAY;
    endfunction

endpackage

// File: rtl/itc_tcell.sv
module itc_tcell (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tgl_i,
    output logic q_o
);
    logic q_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)      q_q <= 1'b0;
        else if (tgl_i) q_q <= ~q_q;
    end

    assign q_o = q_q;

endmodule

// File: rtl/itc_step.sv
module itc_step #(
    parameter int unsigned WIDTH = itc_pkg::ITC_WIDTH,
    parameter int unsigned LAST  = itc_pkg::ITC_LAST
) (
    input  logic [WIDTH-1:0] cur_i,
    output logic [WIDTH-1:0] tgl_o,
    output itc_pkg::step_info_t info_o
);
    import itc_pkg::*;

    logic [WIDTH-1:0] nxt;
    pos_e             pos;

    always_comb begin
        pos = classify(32'(cur_i), LAST);
        unique case (pos)
            POS_RUN:  nxt = cur_i + 1'b1;
            POS_LAST: nxt = cur_i;
            default:  nxt = '0;
        endcase
    end

    // A toggle cell flips exactly where present and next state differ
    assign tgl_o          = cur_i ^ nxt;
    assign info_o.pos     = pos;
    assign info_o.at_last = (pos == POS_LAST);

endmodule

// File: rtl/itc_decode.sv
module itc_decode #(
    parameter int unsigned WIDTH = itc_pkg::ITC_WIDTH,
    parameter int unsigned LAST  = itc_pkg::ITC_LAST
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             armed_i,
    input  logic [WIDTH-1:0] cur_i,
    output logic             term_o
);
    localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST);

    assign term_o = (cur_i == LAST_V);

    // R5
    term_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i || !armed_i)
        term_o |=> term_o);

    // R5
    term_entry_chk: assert property (@(posedge clk_i) disable iff (rst_i || !armed_i)
        $rose(term_o) |-> ($past(cur_i) == LAST_V - 1'b1));

endmodule

// File: rtl/itc_sat_counter.sv
module itc_sat_counter #(
    parameter int unsigned WIDTH = itc_pkg::ITC_WIDTH,
    parameter int unsigned LAST  = itc_pkg::ITC_LAST
) (
    input  logic             clk_i,
    input  logic             rst_i,
    output logic [WIDTH-1:0] count_o,
    output logic             term_o
);
    import itc_pkg::*;

    localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST);

    logic [WIDTH-1:0] cur;
    logic [WIDTH-1:0] tgl;
    step_info_t       info;
    logic             armed_q;

    itc_step #(.WIDTH(WIDTH), .LAST(LAST)) u_step (
        .cur_i  (cur),
        .tgl_o  (tgl),
        .info_o (info)
    );

    for (genvar b = 0; b < WIDTH; b++) begin : g_cell
        itc_tcell u_cell (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .tgl_i (tgl[b]),
            .q_o   (cur[b])
        );
    end

    itc_decode #(.WIDTH(WIDTH), .LAST(LAST)) u_decode (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .armed_i (armed_q),
        .cur_i   (cur),
        .term_o  (term_o)
    );

    assign count_o = cur;

    // Properties stay quiet until a reset has defined the cells
    always_ff @(posedge clk_i) begin
        if (rst_i) armed_q <= 1'b1;
    end

    // R1 R4
    reset_zero_chk: assert property (@(posedge clk_i)
        rst_i |=> (count_o == '0));

    // R2
    advance_chk: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
        (count_o < LAST_V) |=> (count_o == $past(count_o) + 1'b1));

    // R3
    hold_chk: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
        (count_o == LAST_V) |=> (count_o == LAST_V));

    // R6
    range_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
        count_o <= LAST_V);

    // R3
    hold_info_chk: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
        info.at_last |-> (tgl == '0));

endmodule

// File: tb/test_itc_sat_counter.sv
module test_itc_sat_counter;

    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic [2:0] count_o;
    logic       term_o;

    int checks = 0;
    int errors = 0;
    int ref_cnt = 0;
    bit ref_valid = 0;
    bit prev_rst = 0;
    int prev_ref = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk_i = ~clk_i;

    itc_sat_counter i_itc_sat_counter (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .count_o (count_o),
        .term_o  (term_o)
    );

    // Behavioural reference updated at each rising edge
    always @(posedge clk_i) begin
        prev_rst = rst_i;
        prev_ref = ref_cnt;
        if (rst_i) begin
            ref_cnt   = 0;
            ref_valid = 1;
        end else if (ref_cnt < 4) begin
            ref_cnt = ref_cnt + 1;
        end
        cycles++;
    end

    // Compare away from the active edge
    always @(negedge clk_i) begin
        if (ref_valid && !done) begin
            string tag;
            if (prev_rst)          tag = (prev_ref == 0) ? "R1" : "R4";
            else if (prev_ref < 4) tag = "R2";
            else                   tag = "R3";
            checks++;
            if (int'(count_o) != ref_cnt) begin
                errors++;
                $display("FAIL %s count actual=%0d expected=%0d", tag, count_o, ref_cnt);
            end
            checks++;
            if (term_o !== (ref_cnt == 4)) begin
                errors++;
                $display("FAIL R5 term actual=%0b expected=%0b", term_o, (ref_cnt == 4));
            end
            checks++;
            if (int'(count_o) > 4) begin
                errors++;
                $display("FAIL R6 range actual=%0d expected<=4", count_o);
            end
        end
    end

    task automatic run(input bit r, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_i);
            rst_i = r;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        // R1: reset state
        run(1, 2);
        // R2 R3: count up and saturate
        run(0, 10);
        // R4: reset from terminal count
        run(1, 1);
        run(0, 3);
        // R4: reset at intermediate count 2
        run(1, 1);
        run(0, 2);
        run(1, 1);
        run(0, 1);
        // R4: reset held several cycles
        run(1, 4);
        run(0, 8);
        // R4: alternating pulses
        for (int k = 0; k < 6; k++) begin
            run(1, 1);
            run(0, k);
        end
        run(0, 6);
        @(negedge clk_i);
        finish_run();
    end

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

endmodule